// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block holds a free-running up-counter that software cannot read or load. Software controls it only through one 16-bit control word. A write changes the stored control bits only when the upper byte carries the access key 0x5A. Any other upper byte counts as a tampering attempt and at once produces a system reset request. A read always returns the fixed identity byte 0x69 in the upper half, so the key can never be read back from the register.

The counter advances on one of two tick enables, `tick_a` or `tick_b`. It expires when it reaches the value set by one of four parameterised tap positions. What happens at expiry depends on the mode:

- **Watchdog mode:** expiry requests a system reset and sets a sticky cause flag.
- **Interval mode:** expiry sets an interrupt flag and the counter carries on.

The control word also holds a stop bit, a source select, a self-clearing restart strobe and two bits that configure the external non-maskable pin. Those two bits are passed out unchanged to the pin circuitry.

Top module: `keyed_watchdog`

## Requirements
- R1: A write whose upper byte is 0x5A stores the lower byte. From the next cycle the read port returns that byte, except that the restart bit (bit 4) reads as 0.
- R2: A write whose upper byte is not 0x5A pulses `rst_req` for one cycle after the write edge, sets `wd_flag`, and returns the lower byte to 0x00.
- R3: The upper byte of `reg_rdata` is always 0x69.
- R4: A keyed write with bit 4 set restarts the counter from zero. Bit 4 is never stored.
- R5: Bits 1:0 select a tap. Expiry comes 2^TAP_POS[sel] enabled ticks after a restart. The default tap positions are 15, 13, 9 and 6 for selects 0 to 3.
- R6: In watchdog mode (bit 2 = 0), expiry pulses `rst_req`, sets `wd_flag` and returns the lower byte to 0x00.
- R7: In interval mode (bit 2 = 1), expiry sets `int_flag` and never `rst_req`. The counter wraps and expires again every period. `int_ack` clears `int_flag`.
- R8: With the stop bit (bit 3) set, ticks are ignored and the counter does not move.
- R9: Bit 5 selects the tick source: 0 counts `tick_a`, 1 counts `tick_b`. The unselected source is ignored.
- R10: Bit 6 drives `nmi_enable` and bit 7 drives `nmi_falling`. Both read back and neither affects counting.
- R11: After power-on reset the lower byte is 0x00, the flags are clear, and the counter runs from zero in watchdog mode with tap 0.
- R12: `wd_flag` stays set until power-on reset. `int_ack` and reset requests do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| tick_a | input | 1 | Count enable, source 0 |
| tick_b | input | 1 | Count enable, source 1 |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Write data: key in the upper byte, control bits in the lower byte |
| reg_rdata | output | 16 | Read data: identity byte and stored control bits |
| int_ack | input | 1 | Clears the interval flag |
| rst_req | output | 1 | One-cycle system reset request |
| wd_flag | output | 1 | Sticky reset-cause flag |
| int_flag | output | 1 | Interval expiry flag |
| nmi_enable | output | 1 | Pin configuration bit for the non-maskable input |
| nmi_falling | output | 1 | Edge select for the non-maskable input |

## Verification
The checks assume that `reg_wr` and `reg_wdata` change only away from the clock edge and stay stable through the edge that samples them. They also assume that `int_ack` is never raised in the same cycle as an interval expiry that the bench wants to observe. The stimulus changes every input on the falling edge. It acknowledges the interrupt only at least one cycle after the expiry it checks, and places each keyed restart well inside a period, so no expiry and write land on the same edge.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;
   localparam logic [7:0] PASS_KEY = 8'h5A;
   localparam logic [7:0] ID_BYTE  = 8'h69;
   localparam int unsigned NUM_TAPS = 4;
   localparam int unsigned TAP_SEL_W = $clog2(NUM_TAPS);

   typedef struct packed {
      logic                 nmi_fall;
      logic                 nmi_on;
      logic                 src_b;
      logic                 restart;
      logic                 stop;
      logic                 interval;
      logic [TAP_SEL_W-1:0] tap;
   } ctl_t;
endpackage

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
   import keyed_watchdog_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [15:0] wdata,
   input  logic        sys_evt,
   output ctl_t        ctl,
   output logic        key_bad,
   output logic        restart_pulse
);
   logic key_ok;
   ctl_t ctl_nxt;

   assign key_ok        = wr && (wdata[15:8] == PASS_KEY);
   assign key_bad       = wr && (wdata[15:8] != PASS_KEY);
   assign restart_pulse = key_ok && wdata[4];

   always_comb begin
      ctl_nxt = ctl;
      if (sys_evt) begin
         ctl_nxt = '0;
      end else if (key_ok) begin
         ctl_nxt         = ctl_t'(wdata[7:0]);
         ctl_nxt.restart = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl <= '0;
      else        ctl <= ctl_nxt;
   end
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
   import keyed_watchdog_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned TAP_POS [NUM_TAPS] = '{15, 13, 9, 6}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_a,
   input  logic                 tick_b,
   input  logic                 sel_b,
   input  logic                 stop,
   input  logic [TAP_SEL_W-1:0] tap,
   input  logic                 restart,
   input  logic                 flush,
   output logic                 expire
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim [NUM_TAPS];
   logic             step;

   for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
      if (TAP_POS[i] == 0 || TAP_POS[i] > CNT_W) begin : g_bad_tap
         $error("tap position out of counter range");
      end
      assign lim[i] = CNT_W'((64'd1 << TAP_POS[i]) - 64'd1);
   end

   assign step   = (sel_b ? tick_b : tick_a) && !stop;
   assign expire = step && (cnt == lim[tap]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (flush || restart)  cnt <= '0;
      else if (expire)            cnt <= '0;
      else if (step)              cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/wdt_event_unit.sv
module wdt_event_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic interval,
   input  logic key_bad,
   input  logic int_ack,
   output logic sys_evt,
   output logic rst_req,
   output logic wd_flag,
   output logic int_flag
);
   assign sys_evt = key_bad || (expire && !interval);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req  <= 1'b0;
         wd_flag  <= 1'b0;
         int_flag <= 1'b0;
      end else begin
         rst_req <= sys_evt;
         if (sys_evt) wd_flag <= 1'b1;
         if (expire && interval) int_flag <= 1'b1;
         else if (int_ack)       int_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import keyed_watchdog_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned TAP_POS [NUM_TAPS] = '{15, 13, 9, 6}
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_a,
   input  logic        tick_b,
   input  logic        reg_wr,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   input  logic        int_ack,
   output logic        rst_req,
   output logic        wd_flag,
   output logic        int_flag,
   output logic        nmi_enable,
   output logic        nmi_falling
);
   ctl_t ctl;
   logic key_bad, restart_pulse, sys_evt, expire;

   wdt_ctl_reg u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .sys_evt(sys_evt), .ctl(ctl), .key_bad(key_bad),
      .restart_pulse(restart_pulse)
   );

   wdt_tick_counter #(.CNT_W(CNT_W), .TAP_POS(TAP_POS)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
      .sel_b(ctl.src_b), .stop(ctl.stop), .tap(ctl.tap),
      .restart(restart_pulse), .flush(sys_evt), .expire(expire)
   );

   wdt_event_unit u_evt (
      .clk(clk), .rst_n(rst_n), .expire(expire), .interval(ctl.interval),
      .key_bad(key_bad), .int_ack(int_ack), .sys_evt(sys_evt),
      .rst_req(rst_req), .wd_flag(wd_flag), .int_flag(int_flag)
   );

   assign reg_rdata   = {ID_BYTE, ctl};
   assign nmi_enable  = ctl.nmi_on;
   assign nmi_falling = ctl.nmi_fall;
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic [15:0] reg_wdata,
   input logic [15:0] reg_rdata,
   input logic        rst_req,
   input logic        wd_flag,
   input logic        int_flag
);
   a_r1_keyed_store: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_wdata[15:8] == 8'h5A |=>
         rst_req || reg_rdata[7:0] == ($past(reg_wdata[7:0]) & 8'hEF));

   a_r2_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_wdata[15:8] != 8'h5A |=> rst_req && reg_rdata[7:0] == 8'h00);

   a_r3_id_byte: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[15:8] == 8'h69);

   a_r4_restart_unstored: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[4]);

   a_r6_req_sets_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> wd_flag);

   a_r7_int_in_interval: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_flag) |-> $past(reg_rdata[2]) && !rst_req);

   a_r12_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      wd_flag |=> wd_flag);
endmodule

bind keyed_watchdog keyed_watchdog_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .rst_req(rst_req), .wd_flag(wd_flag),
   .int_flag(int_flag)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_a = 1'b1, tick_b = 1'b0;
   logic        reg_wr = 1'b0, int_ack = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        rst_req, wd_flag, int_flag, nmi_enable, nmi_falling;
   int          n_chk = 0, n_err = 0, cyc = 0;

   always #2.5 clk = ~clk;

   keyed_watchdog u_dut (
      .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .int_ack(int_ack), .rst_req(rst_req), .wd_flag(wd_flag),
      .int_flag(int_flag), .nmi_enable(nmi_enable), .nmi_falling(nmi_falling)
   );

   // {write data, expected read data, expected reset request}
   localparam logic [32:0] VEC [9] = '{
      {16'h5A00, 16'h6900, 1'b0},
      {16'h5AC1, 16'h69C1, 1'b0},
      {16'h5A1E, 16'h690E, 1'b0},
      {16'hA5C1, 16'h6900, 1'b1},
      {16'h5A2D, 16'h692D, 1'b0},
      {16'h5A55, 16'h6945, 1'b0},
      {16'h0000, 16'h6900, 1'b1},
      {16'h5A08, 16'h6908, 1'b0},
      {16'h5B08, 16'h6900, 1'b1}
   };

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [15:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
      @(posedge clk); @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ack();
      int_ack = 1'b1; @(posedge clk); @(negedge clk); int_ack = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 120000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=running expected=done");
         report();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R11 reset state
      chk("R11 rdata", reg_rdata, 16'h6900);
      chk("R11 flags", {rst_req, wd_flag, int_flag, nmi_enable, nmi_falling}, 5'b0);
      // R11/R6 default watchdog tap 0 expires after 2^15 ticks
      edges(32767);
      chk("R6 no early req", rst_req, 1'b0);
      edges(1);
      chk("R6 req at expiry", rst_req, 1'b1);
      chk("R6 cause flag", wd_flag, 1'b1);
      chk("R6 ctl default", reg_rdata, 16'h6900);
      edges(1);
      chk("R6 single pulse", rst_req, 1'b0);

      // R1 R2 R3 vector table
      for (int i = 0; i < 9; i++) begin
         wr_reg(VEC[i][32:17]);
         chk($sformatf("R1/R2/R3 vec%0d rdata", i), reg_rdata, VEC[i][16:1]);
         chk($sformatf("R2 vec%0d rst_req", i), rst_req, VEC[i][0]);
      end

      // R5 tap 3 and tap 2 in watchdog mode
      wr_reg(16'h5A13);
      edges(63); chk("R5 tap3 early", rst_req, 1'b0);
      edges(1);  chk("R5 tap3 expiry", rst_req, 1'b1);
      wr_reg(16'h5A12);
      edges(511); chk("R5 tap2 early", rst_req, 1'b0);
      edges(1);   chk("R5 tap2 expiry", rst_req, 1'b1);

      // R7 interval mode
      wr_reg(16'h5A17);
      edges(63); chk("R7 early", int_flag, 1'b0);
      edges(1);  chk("R7 int set", int_flag, 1'b1);
      chk("R7 no reset req", rst_req, 1'b0);
      chk("R7 mode kept", reg_rdata, 16'h6907);
      ack();     chk("R7 ack clears", int_flag, 1'b0);
      edges(62); chk("R7 second early", int_flag, 1'b0);
      edges(1);  chk("R7 second period", int_flag, 1'b1);
      ack();

      // R4 restart mid-period
      wr_reg(16'h5A17);
      edges(40);
      wr_reg(16'h5A17);
      edges(63); chk("R4 restart delays", int_flag, 1'b0);
      edges(1);  chk("R4 expiry after restart", int_flag, 1'b1);
      ack();

      // R8 stop bit
      wr_reg(16'h5A1F);
      edges(200); chk("R8 stopped", int_flag, 1'b0);
      wr_reg(16'h5A07);
      edges(63); chk("R8 resume early", int_flag, 1'b0);
      edges(1);  chk("R8 resume expiry", int_flag, 1'b1);
      ack();

      // R9 source select
      wr_reg(16'h5A37);
      edges(100); chk("R9 tick_a ignored", int_flag, 1'b0);
      tick_b = 1'b1;
      edges(63); chk("R9 tick_b early", int_flag, 1'b0);
      edges(1);  chk("R9 tick_b expiry", int_flag, 1'b1);
      ack(); tick_b = 1'b0;

      // R10 pin configuration bits
      wr_reg(16'h5AD7);
      chk("R10 readback", reg_rdata, 16'h69C7);
      chk("R10 pins", {nmi_enable, nmi_falling}, 2'b11);
      edges(63); chk("R10 no count effect early", int_flag, 1'b0);
      edges(1);  chk("R10 no count effect", int_flag, 1'b1);
      ack();

      // R12 cause flag sticky until power-on reset
      chk("R12 kept after ack", wd_flag, 1'b1);
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      chk("R12 cleared by POR", wd_flag, 1'b0);
      chk("R11 POR rdata", reg_rdata, 16'h6900);
      report();
   end
endmodule